// File: doc/BRIEF.md
# Serial Front-End Readout Packetizer

This block receives a one-bit serial line from a front-end electronics module and packs what it sees into 16-bit words for a record FIFO. The line sits at zero while idle. A one marks the start of a record, and that start bit counts as part of the record. What follows depends on the mode. It is either a fixed 32-bit command response or a variable-length event record. An event record has a 39-bit header followed by as many 15-bit values as there are set bits in the header's hit map.

Words are written to the FIFO in cells. Each cell opens with a dummy header entry that carries the announce and type markers. The payload words follow, and the last payload entry of a cell carries the cell-end and truncate flags. Every entry also carries an odd-parity flag. A long event record spans several cells. Once the final word of a record has been written, a one-cycle interrupt pulse fires. While the FIFO reports full, no write is issued, and a small internal word queue absorbs the serial words that keep arriving.

Top module: `fe_readout_pktzr`

## Requirements
- R1: While `sdata_i` stays 0, no record starts and no FIFO write occurs. A 1 seen while idle is the start bit of a new record.
- R2: With `resp_mode_i` high at the start bit, the record is 32 bits including the start bit. It is written as two payload words, first received bit at bit 15 of the first word.
- R3: With `resp_mode_i` low at the start bit, the first 39 bits (start included) form the header. It is written as three words: the first holds 9 zero bits above the first 7 header bits, and the next two hold 16 header bits each, first received bit in the MSB.
- R4: The number of 15-bit values following the header equals the number of ones in header bits [21:4] (HIT_LSB=4, 18 bits; header bit 38 is the start bit). Each value is written as one word with bit 15 zero. The record ends after the last value.
- R5: Every cell starts with an entry whose data is HDR_WORD (default 16'h5A00) and whose flags bit 0 (announce) and bit 1 (type) are both 1. Payload entries have both bits 0.
- R6: Flags bit 2 of every written entry makes the 16 data bits plus that bit hold an odd number of ones.
- R7: A cell holds at most CELL_WORDS (default 8) payload words. Flags bit 3 (cell end) is set only on the last payload entry of each cell. The entries of a record appear in order with nothing missing or extra.
- R8: Flags bit 4 (truncate) is set on the cell-end entry of every cell except the last cell of a record, and is 0 everywhere else.
- R9: `irq_o` is high for exactly one cycle, in the cycle after the write of the record's final word.
- R10: While `fifo_full_i` is high, `fifo_we_o` stays low. Words held back are written afterwards, in order and unchanged.
- R11: The mode is taken at the start bit. A change of `resp_mode_i` during a record does not alter how that record is parsed.
- R12: During reset, `fifo_we_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; serial bits sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdata_i | input | 1 | Serial data line from the front end, MSB first |
| resp_mode_i | input | 1 | 1 = fixed command response, 0 = event record |
| fifo_full_i | input | 1 | Record FIFO full; holds off writes |
| fifo_we_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 16 | FIFO data word |
| fifo_flag_o | output | 5 | {truncate, cell end, parity, type, announce} |
| irq_o | output | 1 | One-cycle pulse after a record's last word is written |

## Verification
A data word is pushed into the queue on the edge that samples its final bit. The first write of a cell, its header entry, can happen on the next edge, and payload entries follow one per edge while the FIFO is not full. The interrupt rises one edge after the last payload write. Because of these latencies, the bench never predicts absolute cycles for data. It logs every strobed entry half a cycle after the edge on which the outputs change, then compares the log against a record-level model once the interrupt count advances. Interrupt timing is checked by looking, at each sample, at whether the previous sample held a final, non-truncated cell-end write. Back-pressure is checked by counting any write seen while full.

// File: rtl/fe_rd_pkg.sv
package fe_rd_pkg;
  localparam int WORD_W = 16;
  localparam int FLAG_W = 5;
  localparam int FLG_ANN = 0;
  localparam int FLG_TYP = 1;
  localparam int FLG_PAR = 2;
  localparam int FLG_END = 3;
  localparam int FLG_TRN = 4;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic  last;
    word_t data;
  } qent_t;

  typedef enum logic [2:0] {
    D_IDLE, D_R0, D_R1, D_H0, D_H1, D_H2, D_VAL
  } dstate_e;
endpackage

// File: rtl/fe_rd_deser.sv
module fe_rd_deser
  import fe_rd_pkg::*;
#(
  parameter int HDR_BITS = 39,
  parameter int VAL_BITS = 15,
  parameter int HIT_LSB  = 4,
  parameter int HIT_W    = 18
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sdata_i,
  input  logic  mode_i,
  output logic  push_o,
  output qent_t push_ent_o
);
  localparam int H0_LEN = HDR_BITS - 2 * WORD_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int HC_W   = $clog2(HIT_W + 1);

  dstate_e             st;
  logic [CNT_W-1:0]    bit_cnt, fld_len;
  logic [HDR_BITS-1:0] sh, sh_nxt;
  logic [HC_W-1:0]     val_left, hit_cnt;
  logic                fld_done;
  word_t               mask;

  always_comb begin
    sh_nxt = {sh[HDR_BITS-2:0], sdata_i};
    unique case (st)
      D_H0:    fld_len = CNT_W'(H0_LEN);
      D_VAL:   fld_len = CNT_W'(VAL_BITS);
      default: fld_len = CNT_W'(WORD_W);
    endcase
    fld_done = (st != D_IDLE) && ((bit_cnt + 1'b1) == fld_len);
    hit_cnt = '0;
    for (int i = 0; i < HIT_W; i++) hit_cnt = hit_cnt + HC_W'(sh_nxt[HIT_LSB+i]);
    // padding zeros land above the field
    mask = word_t'((32'd1 << fld_len) - 32'd1);
    push_o          = fld_done;
    push_ent_o.data = sh_nxt[WORD_W-1:0] & mask;
    unique case (st)
      D_R1:    push_ent_o.last = 1'b1;
      D_H2:    push_ent_o.last = (hit_cnt == '0);
      D_VAL:   push_ent_o.last = (val_left == HC_W'(1));
      default: push_ent_o.last = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= D_IDLE;
      bit_cnt  <= '0;
      sh       <= '0;
      val_left <= '0;
    end else begin
      sh <= sh_nxt;
      if (st == D_IDLE) begin
        if (sdata_i) begin
          st      <= mode_i ? D_R0 : D_H0;
          bit_cnt <= CNT_W'(1);
        end
      end else if (fld_done) begin
        bit_cnt <= '0;
        unique case (st)
          D_R0: st <= D_R1;
          D_R1: st <= D_IDLE;
          D_H0: st <= D_H1;
          D_H1: st <= D_H2;
          D_H2: begin
            st       <= (hit_cnt == '0) ? D_IDLE : D_VAL;
            val_left <= hit_cnt;
          end
          default: begin
            if (val_left == HC_W'(1)) st <= D_IDLE;
            val_left <= val_left - 1'b1;
          end
        endcase
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fe_rd_wordq.sv
module fe_rd_wordq
  import fe_rd_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  qent_t push_ent_i,
  input  logic  pop_i,
  output logic  valid_o,
  output qent_t head_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW:0] FULL_CNT = (PW + 1)'(DEPTH);

  qent_t         mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;
  logic          do_push, do_pop;

  assign do_push = push_i && (cnt != FULL_CNT);
  assign do_pop  = pop_i && (cnt != '0);
  assign valid_o = (cnt != '0);
  assign head_o  = mem[rp];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp] <= push_ent_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      unique case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/fe_rd_cellfmt.sv
module fe_rd_cellfmt
  import fe_rd_pkg::*;
#(
  parameter int    CELL_WORDS = 8,
  parameter word_t HDR_WORD   = 16'h5A00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_full_i,
  input  logic              q_valid_i,
  input  qent_t             q_head_i,
  output logic              q_pop_o,
  output logic              fifo_we_o,
  output word_t             fifo_data_o,
  output logic [FLAG_W-1:0] fifo_flag_o,
  output logic              irq_o
);
  localparam int PCW = $clog2(CELL_WORDS + 1);

  logic           in_cell, go, cell_end;
  logic [PCW-1:0] pay_cnt;

  always_comb begin
    go        = q_valid_i && !fifo_full_i;
    fifo_we_o = go;
    q_pop_o   = go && in_cell;
    cell_end  = q_head_i.last || (pay_cnt == PCW'(CELL_WORDS - 1));
    fifo_flag_o = '0;
    if (!in_cell) begin
      fifo_data_o          = HDR_WORD;
      fifo_flag_o[FLG_ANN] = 1'b1;
      fifo_flag_o[FLG_TYP] = 1'b1;
    end else begin
      fifo_data_o          = q_head_i.data;
      fifo_flag_o[FLG_END] = cell_end;
      fifo_flag_o[FLG_TRN] = cell_end && !q_head_i.last;
    end
    fifo_flag_o[FLG_PAR] = ~^fifo_data_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cell <= 1'b0;
      pay_cnt <= '0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= go && in_cell && q_head_i.last;
      if (go) begin
        if (!in_cell) begin
          in_cell <= 1'b1;
          pay_cnt <= '0;
        end else if (cell_end) begin
          in_cell <= 1'b0;
        end else begin
          pay_cnt <= pay_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fe_readout_pktzr.sv
module fe_readout_pktzr
  import fe_rd_pkg::*;
#(
  parameter int    CELL_WORDS = 8,
  parameter int    QDEPTH     = 4,
  parameter int    HDR_BITS   = 39,
  parameter int    VAL_BITS   = 15,
  parameter int    HIT_LSB    = 4,
  parameter int    HIT_W      = 18,
  parameter word_t HDR_WORD   = 16'h5A00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  input  logic              resp_mode_i,
  input  logic              fifo_full_i,
  output logic              fifo_we_o,
  output logic [WORD_W-1:0] fifo_data_o,
  output logic [FLAG_W-1:0] fifo_flag_o,
  output logic              irq_o
);
  logic  push, pop, q_valid;
  qent_t push_ent, q_head;

  fe_rd_deser #(
    .HDR_BITS(HDR_BITS), .VAL_BITS(VAL_BITS), .HIT_LSB(HIT_LSB), .HIT_W(HIT_W)
  ) u_deser (
    .clk_i(clk_i), .rst_ni(rst_ni), .sdata_i(sdata_i), .mode_i(resp_mode_i),
    .push_o(push), .push_ent_o(push_ent)
  );

  fe_rd_wordq #(.DEPTH(QDEPTH)) u_wordq (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .push_ent_i(push_ent),
    .pop_i(pop), .valid_o(q_valid), .head_o(q_head)
  );

  fe_rd_cellfmt #(.CELL_WORDS(CELL_WORDS), .HDR_WORD(HDR_WORD)) u_cellfmt (
    .clk_i(clk_i), .rst_ni(rst_ni), .fifo_full_i(fifo_full_i),
    .q_valid_i(q_valid), .q_head_i(q_head), .q_pop_o(pop),
    .fifo_we_o(fifo_we_o), .fifo_data_o(fifo_data_o),
    .fifo_flag_o(fifo_flag_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/fe_readout_pktzr_chk.sv
module fe_readout_pktzr_chk
  import fe_rd_pkg::*;
#(
  parameter int    CELL_WORDS = 8,
  parameter word_t HDR_WORD   = 16'h5A00
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fifo_full_i,
  input logic              fifo_we_o,
  input logic [WORD_W-1:0] fifo_data_o,
  input logic [FLAG_W-1:0] fifo_flag_o,
  input logic              irq_o
);
  logic [7:0] pay_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pay_seen <= '0;
    else if (fifo_we_o && fifo_flag_o[FLG_ANN]) pay_seen <= '0;
    else if (fifo_we_o) pay_seen <= pay_seen + 1'b1;
  end

  a_r10_no_write_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_i |-> !fifo_we_o);

  a_r6_odd_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_we_o |-> (^{fifo_data_o, fifo_flag_o[FLG_PAR]}) == 1'b1);

  a_r5_header_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_we_o && fifo_flag_o[FLG_ANN]) |->
      (fifo_flag_o[FLG_TYP] && fifo_data_o == HDR_WORD && !fifo_flag_o[FLG_END]));

  a_r8_trunc_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_we_o && fifo_flag_o[FLG_TRN]) |-> fifo_flag_o[FLG_END]);

  a_r7_cell_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_we_o && !fifo_flag_o[FLG_ANN]) |-> (pay_seen < 8'(CELL_WORDS)));

  a_r9_irq_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r9_irq_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(fifo_we_o && fifo_flag_o[FLG_END] && !fifo_flag_o[FLG_TRN]));
endmodule

bind fe_readout_pktzr fe_readout_pktzr_chk #(
  .CELL_WORDS(CELL_WORDS), .HDR_WORD(HDR_WORD)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fifo_full_i(fifo_full_i),
  .fifo_we_o(fifo_we_o), .fifo_data_o(fifo_data_o),
  .fifo_flag_o(fifo_flag_o), .irq_o(irq_o)
);

// File: tb/fe_readout_pktzr_tb.sv
`timescale 1ns/1ps
module fe_readout_pktzr_tb;
  localparam int          CW  = 8;
  localparam logic [15:0] HW  = 16'h5A00;
  localparam int          HL  = 4;
  localparam int          NV  = 6;
  // {resp_mode, hit_map[17:0], body[38:0]}
  localparam logic [57:0] VEC [NV] = '{
    {1'b1, 18'h00000, 39'h00C35A0F0F},
    {1'b0, 18'h00000, 39'h123456789A},
    {1'b0, 18'h0001F, 39'h2ABCDE0013},
    {1'b0, 18'h30107, 39'h15A5A5A5A5},
    {1'b0, 18'h3FFFF, 39'h0F0F0F0F0F},
    {1'b1, 18'h00000, 39'h00FFFFFFFF}
  };

  logic clk = 0, rst_ni = 0, sdata = 0, resp_mode = 0, full = 0;
  logic        we, irq;
  logic [15:0] data;
  logic [4:0]  flag;

  int checks = 0, errors = 0, cap_n = 0, irq_n = 0, irq_bad = 0, wr_full = 0, exp_n = 0;
  logic [20:0] cap [256];
  logic [20:0] expv [64];
  logic [15:0] ew [32];
  bit prev_last = 0, done = 0;

  always #2.5 clk = ~clk;

  fe_readout_pktzr u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sdata_i(sdata), .resp_mode_i(resp_mode),
    .fifo_full_i(full), .fifo_we_o(we), .fifo_data_o(data),
    .fifo_flag_o(flag), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor half a cycle after the edge that updates outputs
  initial forever begin
    @(negedge clk); #1;
    if (rst_ni) begin
      if (we && full) wr_full++;
      if (irq != prev_last) irq_bad++;
      if (we && cap_n < 256) begin
        cap[cap_n] = {flag, data};
        cap_n++;
      end
      prev_last = we && flag[3] && !flag[4];
    end
  end

  function automatic logic [14:0] val_of(input int k);
    return 15'((k * 1657 + 677) & 32'h7FFF);
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk);
    sdata = b;
  endtask

  task automatic build_exp(input int nw);
    int idx = 0;
    exp_n = 0;
    while (idx < nw) begin
      int chunk = (nw - idx > CW) ? CW : nw - idx;
      expv[exp_n] = {2'b00, ~^HW, 2'b11, HW};
      exp_n++;
      for (int j = 0; j < chunk; j++) begin
        logic e = (j == chunk - 1);
        logic t = e && (idx + chunk < nw);
        expv[exp_n] = {t, e, ~^ew[idx+j], 2'b00, ew[idx+j]};
        exp_n++;
      end
      idx += chunk;
    end
  endtask

  task automatic run_pkt(input logic md, input logic [17:0] hm, input logic [38:0] body,
                         input bit toggle, input bit hold);
    logic [38:0] h;
    logic [31:0] r;
    int nv = 0, nw, base, irq0, t;
    string dtag;
    r = {1'b1, body[30:0]};
    h = body;
    h[38] = 1'b1;
    h[HL +: 18] = hm;
    for (int i = 0; i < 18; i++) nv += int'(hm[i]);
    if (md) begin
      ew[0] = r[31:16]; ew[1] = r[15:0]; nw = 2; dtag = "R2";
    end else begin
      ew[0] = {9'b0, h[38:32]}; ew[1] = h[31:16]; ew[2] = h[15:0];
      for (int k = 0; k < nv; k++) ew[3+k] = {1'b0, val_of(k)};
      nw = 3 + nv; dtag = "R3 R4";
    end
    build_exp(nw);
    base = cap_n;
    irq0 = irq_n;
    @(negedge clk);
    if (hold) full = 1'b1;
    resp_mode = md;
    sdata = 1'b1;
    if (md) begin
      for (int i = 30; i >= 0; i--) send_bit(r[i]);
    end else begin
      for (int i = 37; i >= 0; i--) begin
        send_bit(h[i]);
        if (toggle && i == 35) resp_mode = 1'b1;  // R11 mid-record change
      end
      for (int k = 0; k < nv; k++) begin
        logic [14:0] v = val_of(k);
        for (int i = 14; i >= 0; i--) send_bit(v[i]);
      end
    end
    send_bit(1'b0);
    if (hold) begin
      repeat (20) @(negedge clk);
      chk(cap_n == base, "R10 held", 32'(cap_n - base), 0);
      full = 1'b0;
    end
    t = 0;
    while (irq_n == irq0 && t < 2000) begin
      @(negedge clk);
      if (irq) irq_n++;
      t++;
    end
    repeat (3) @(negedge clk);
    chk(irq_n == irq0 + 1, "R9 count", 32'(irq_n - irq0), 1);
    chk(cap_n - base == exp_n, "R7 entries", 32'(cap_n - base), 32'(exp_n));
    for (int i = 0; i < exp_n; i++) begin
      chk(cap[base+i][15:0] == expv[i][15:0], dtag, 32'(cap[base+i][15:0]), 32'(expv[i][15:0]));
      chk(cap[base+i][20:16] == expv[i][20:16], "R5 R6 R7 R8 flags",
          32'(cap[base+i][20:16]), 32'(expv[i][20:16]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9 act=%0d exp=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!we && !irq, "R12 reset", {30'b0, we, irq}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (50) @(negedge clk);
    chk(cap_n == 0 && irq_n == 0, "R1 idle", 32'(cap_n), 0);
    for (int v = 0; v < NV; v++) begin
      run_pkt(VEC[v][57], VEC[v][56:39], VEC[v][38:0], 1'b0, 1'b0);
      repeat (5) @(negedge clk);
    end
    run_pkt(1'b1, 18'h0, 39'h0012345678, 1'b0, 1'b1);  // R10 back-pressure
    run_pkt(1'b0, 18'h00F00, 39'h0A0A0A0A0A, 1'b1, 1'b0);  // R11
    chk(wr_full == 0, "R10 write while full", 32'(wr_full), 0);
    chk(irq_bad == 0, "R9 irq timing", 32'(irq_bad), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule